// File: doc/BRIEF.md
# Edge-Latched Status and Interrupt Bank

This block watches a set of monitored inputs and a small group of lock-indication inputs. Software sees them through byte-wide registers on a simple parallel bus with single-cycle read and write strobes. Each monitored input has two views. The live view shows the input level as it is at the moment of the read. The latched view remembers a chosen transition until software clears it. Each latched bit has its own 2-bit edge mode. A per-bit enable mask combines the latched bits into a single active-high interrupt request.

The lock-indication bits are latched in the same way, with their own edge modes, but they follow the opposite clear rule: writing 0 clears a bit. They never reach the interrupt request. The interrupt output comes from a two-state machine. IRQ_IDLE moves to IRQ_RAISED when any enabled latched bit is set. IRQ_RAISED moves back to IRQ_IDLE when none is set. The output is high exactly in IRQ_RAISED.

The register map with the default N_BYTES=2 and N_LOCK=4 is as follows:
- 0x00–0x01: live inputs.
- 0x02–0x03: latched bits.
- 0x04–0x05: interrupt enables.
- 0x06–0x09: edge modes, four bits per byte, with bit i using bits [2i+1:2i] of its byte.
- 0x0A: live lock inputs.
- 0x0B: latched lock bits.
- 0x0C: lock edge modes.

Register bytes are 8 bits wide, bit 7 MSB. Input bit 8b+k maps to bit k of byte b. Read data appears on rd_data one cycle after rd_en and holds until the next read.

Top module: `status_irq_bank`

## Requirements
- R1: After reset the latched bits, lock latched bits and enables read 0x00, every source edge-mode byte reads 0x55 (rising), the lock edge-mode byte reads 0xFF (both), and irq is 0.
- R2: A read of a live register returns, on rd_data in the next cycle, the input levels sampled at the clock edge where rd_en was high.
- R3: The edge mode codes are 00 none, 01 rising, 10 falling and 11 either. A matching change seen at a clock edge sets the latched bit at that same edge.
- R4: Writing a latched source byte clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: When a set event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: irq equals the OR of (latched & enable) as it stood before the previous clock edge. It rises one cycle after an enabled bit latches and falls one cycle after the last enabled bit is cleared or disabled.
- R7: A lock latched bit is cleared by writing 0 to its position, is unchanged by writing 1, and never affects irq.
- R8: Writes to live registers have no effect. Unused bits (lock bits above N_LOCK) and unmapped addresses read as 0.
- R9: The enable and edge-mode registers read back the last value written.
- R10: Input levels present when reset is released do not count as transitions; the first clock edge after reset only records the levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 8*N_BYTES | Monitored inputs |
| lock_in | input | N_LOCK | Lock-indication inputs |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | AW | Register address |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, registered |
| irq | output | 1 | Active-high interrupt request |

## Verification
On every cycle, the assertions check four things: that irq follows the previous cycle's enabled latched bits, that zero bits of a source clear write and one bits of a lock clear write never drop a latched bit, and that unused lock bits read as zero. The bench's scenarios are needed for the rest: each edge mode against chosen transitions, set-wins collisions, the default values after reset, live readback timing, and the suppression of false transitions at reset release.

// File: rtl/sib_pkg.sv
package sib_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/sib_edge_latch.sv
module sib_edge_latch
    import sib_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           primed,
    input  logic [W-1:0]   sig,
    input  logic [2*W-1:0] mode,
    input  logic [W-1:0]   clr,
    output logic [W-1:0]   lat
);

    logic [W-1:0] prev_q;
    logic [W-1:0] lat_q;
    logic [W-1:0] hit;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic h;
        always_comb begin
            case (edge_mode_e'(mode[2*i +: 2]))
                EDGE_RISE: h = sig[i] & ~prev_q[i];
                EDGE_FALL: h = ~sig[i] & prev_q[i];
                EDGE_BOTH: h = sig[i] ^ prev_q[i];
                default:   h = 1'b0;
            endcase
        end
        assign hit[i] = h & primed;
    end

    // a set event overrides a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            lat_q  <= '0;
        end else begin
            prev_q <= sig;
            lat_q  <= (lat_q & ~clr) | hit;
        end
    end

    assign lat = lat_q;

endmodule

// File: rtl/sib_irq_fsm.sv
module sib_irq_fsm
    import sib_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    output logic irq
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pend)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pend) state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/status_irq_bank.sv
module status_irq_bank
    import sib_pkg::*;
#(
    parameter int N_BYTES = 2,
    parameter int N_LOCK  = 4,
    parameter int AW      = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BYTE_W*N_BYTES-1:0] evt_in,
    input  logic [N_LOCK-1:0]         lock_in,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [AW-1:0]             addr,
    input  logic [BYTE_W-1:0]         wr_data,
    output logic [BYTE_W-1:0]         rd_data,
    output logic                      irq
);

    localparam int N_SRC     = BYTE_W * N_BYTES;
    localparam int A_LIVE    = 0;
    localparam int A_LAT     = N_BYTES;
    localparam int A_EN      = 2 * N_BYTES;
    localparam int A_EDGE    = 3 * N_BYTES;
    localparam int N_EDGE    = 2 * N_BYTES;
    localparam int A_LK_LIVE = 5 * N_BYTES;
    localparam int A_LK_LAT  = A_LK_LIVE + 1;
    localparam int A_LK_EDGE = A_LK_LIVE + 2;
    localparam logic [2*N_SRC-1:0]  EDGE_DEF    = {N_SRC{EDGE_RISE}};
    localparam logic [2*N_LOCK-1:0] LK_EDGE_DEF = {N_LOCK{EDGE_BOTH}};

    logic [N_SRC-1:0]    en_q;
    logic [2*N_SRC-1:0]  edge_q;
    logic [2*N_LOCK-1:0] lk_edge_q;
    logic                primed_q;
    logic [N_SRC-1:0]    src_clr;
    logic [N_LOCK-1:0]   lk_clr;
    logic [N_SRC-1:0]    src_lat;
    logic [N_LOCK-1:0]   lk_lat;
    logic [BYTE_W-1:0]   rd_next;
    logic                pend;

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= '0;
            edge_q    <= EDGE_DEF;
            lk_edge_q <= LK_EDGE_DEF;
            primed_q  <= 1'b0;
        end else begin
            primed_q <= 1'b1;
            if (wr_en) begin
                for (int b = 0; b < N_BYTES; b++) begin
                    if (addr == AW'(A_EN + b)) en_q[BYTE_W*b +: BYTE_W] <= wr_data;
                end
                for (int r = 0; r < N_EDGE; r++) begin
                    if (addr == AW'(A_EDGE + r)) edge_q[BYTE_W*r +: BYTE_W] <= wr_data;
                end
                if (addr == AW'(A_LK_EDGE)) lk_edge_q <= wr_data[2*N_LOCK-1:0];
            end
        end
    end

    // clear strobes: ones clear source bits, zeros clear lock bits
    always_comb begin
        src_clr = '0;
        for (int b = 0; b < N_BYTES; b++) begin
            if (wr_en && addr == AW'(A_LAT + b)) src_clr[BYTE_W*b +: BYTE_W] = wr_data;
        end
        lk_clr = (wr_en && addr == AW'(A_LK_LAT)) ? ~wr_data[N_LOCK-1:0] : '0;
    end

    sib_edge_latch #(.W(N_SRC)) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .primed (primed_q),
        .sig    (evt_in),
        .mode   (edge_q),
        .clr    (src_clr),
        .lat    (src_lat)
    );

    sib_edge_latch #(.W(N_LOCK)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .primed (primed_q),
        .sig    (lock_in),
        .mode   (lk_edge_q),
        .clr    (lk_clr),
        .lat    (lk_lat)
    );

    assign pend = |(src_lat & en_q);

    sib_irq_fsm u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .irq   (irq)
    );

    // read multiplexer
    always_comb begin
        rd_next = '0;
        for (int b = 0; b < N_BYTES; b++) begin
            if (addr == AW'(A_LIVE + b)) rd_next = evt_in[BYTE_W*b +: BYTE_W];
            if (addr == AW'(A_LAT + b))  rd_next = src_lat[BYTE_W*b +: BYTE_W];
            if (addr == AW'(A_EN + b))   rd_next = en_q[BYTE_W*b +: BYTE_W];
        end
        for (int r = 0; r < N_EDGE; r++) begin
            if (addr == AW'(A_EDGE + r)) rd_next = edge_q[BYTE_W*r +: BYTE_W];
        end
        if (addr == AW'(A_LK_LIVE)) rd_next[N_LOCK-1:0]   = lock_in;
        if (addr == AW'(A_LK_LAT))  rd_next[N_LOCK-1:0]   = lk_lat;
        if (addr == AW'(A_LK_EDGE)) rd_next[2*N_LOCK-1:0] = lk_edge_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

endmodule

// File: rtl/sib_chk.sv
module sib_chk #(
    parameter int N_BYTES = 2,
    parameter int N_LOCK  = 4,
    parameter int AW      = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 irq,
    input logic [8*N_BYTES-1:0] src_lat,
    input logic [8*N_BYTES-1:0] en_q,
    input logic [N_LOCK-1:0]    lk_lat,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [AW-1:0]        addr,
    input logic [7:0]           wr_data,
    input logic [7:0]           rd_data
);

    localparam int A_LAT     = N_BYTES;
    localparam int A_LK_LIVE = 5 * N_BYTES;
    localparam int A_LK_LAT  = A_LK_LIVE + 1;

    // R6
    irq_follows_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == $past(|(src_lat & en_q))));

    // R4
    zero_keeps_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(A_LAT)) |=>
        ((($past(src_lat[7:0]) & ~$past(wr_data)) & ~src_lat[7:0]) == 8'h00));

    // R7
    one_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(A_LK_LAT)) |=>
        ((($past(lk_lat) & $past(wr_data[N_LOCK-1:0])) & ~lk_lat) == '0));

    // R8
    unused_lock_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(A_LK_LIVE)) |=> ((rd_data >> N_LOCK) == 8'h00));

endmodule

bind status_irq_bank sib_chk #(.N_BYTES(N_BYTES), .N_LOCK(N_LOCK), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .src_lat (src_lat),
    .en_q    (en_q),
    .lk_lat  (lk_lat),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data)
);

// File: tb/sim_status_irq_bank.sv
module sim_status_irq_bank;

    localparam int NB = 2;
    localparam int NL = 4;
    localparam int AW = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [15:0]   evt   = '0;
    logic [3:0]    lk    = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr  = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rd_data;
    logic          irq;

    status_irq_bank #(.N_BYTES(NB), .N_LOCK(NL), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_in(evt), .lock_in(lk),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wdata),
        .rd_data(rd_data), .irq(irq)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    string rd_tag  = "R1";
    string irq_tag = "R6";

    // reference state
    logic [15:0] m_prev, m_lat, m_en, m_clr, m_hit;
    logic [31:0] m_edge;
    logic [3:0]  m_lk_prev, m_lk_lat, m_lk_clr, m_lk_hit;
    logic [7:0]  m_lk_edge, m_rd;
    logic        m_primed, m_irq, rd_pend;

    function automatic logic hitf(input logic [1:0] m, input logic p, input logic c);
        case (m)
            2'b01:   return c & ~p;
            2'b10:   return ~c & p;
            2'b11:   return c ^ p;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] rdm(input logic [AW-1:0] a);
        if (a < 2)       return evt[a*8 +: 8];
        else if (a < 4)  return m_lat[(a-2)*8 +: 8];
        else if (a < 6)  return m_en[(a-4)*8 +: 8];
        else if (a < 10) return m_edge[(a-6)*8 +: 8];
        else if (a == 10) return {4'h0, lk};
        else if (a == 11) return {4'h0, m_lk_lat};
        else if (a == 12) return m_lk_edge;
        else return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = '0; m_lat = '0; m_en = '0; m_edge = {16{2'b01}};
            m_lk_prev = '0; m_lk_lat = '0; m_lk_edge = 8'hFF;
            m_primed = 1'b0; m_irq = 1'b0; m_rd = '0; rd_pend = 1'b0;
        end else begin
            rd_pend = rd_en;
            if (rd_en) m_rd = rdm(addr);
            m_irq = |(m_lat & m_en);
            m_clr = '0; m_lk_clr = '0; m_hit = '0; m_lk_hit = '0;
            if (wr_en) begin
                if (addr == 2) m_clr[7:0]  = wdata;
                if (addr == 3) m_clr[15:8] = wdata;
                if (addr == 11) m_lk_clr = ~wdata[3:0];
            end
            if (m_primed) begin
                for (int i = 0; i < 16; i++) m_hit[i] = hitf(m_edge[2*i +: 2], m_prev[i], evt[i]);
                for (int i = 0; i < 4; i++) m_lk_hit[i] = hitf(m_lk_edge[2*i +: 2], m_lk_prev[i], lk[i]);
            end
            if (wr_en) begin
                if (addr == 4 || addr == 5) m_en[(addr-4)*8 +: 8] = wdata;
                if (addr >= 6 && addr < 10) m_edge[(addr-6)*8 +: 8] = wdata;
                if (addr == 12) m_lk_edge = wdata;
            end
            m_lat = (m_lat & ~m_clr) | m_hit;
            m_lk_lat = (m_lk_lat & ~m_lk_clr) | m_lk_hit;
            m_prev = evt; m_lk_prev = lk; m_primed = 1'b1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done && n_chk >= 0) begin
            if (rst_n) begin
                check(irq === m_irq, irq_tag, {7'h0, irq}, {7'h0, m_irq});
                if (rd_pend) check(rd_data === m_rd, rd_tag, rd_data, m_rd);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        @(negedge clk); rd_tag = tag; rd_en = 1'b1; wr_en = 1'b0; addr = a;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic drive(input logic [15:0] v, input logic [3:0] l);
        @(negedge clk); evt = v; lk = l;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        // R10: levels high during reset must not latch on release
        evt = 16'hFFFF; lk = 4'hF;
        repeat (3) @(negedge clk);
        check(irq === 1'b0 && rd_data === 8'h00, "R1", {7'h0, irq}, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rd(2, "R10"); rd(3, "R10"); rd(11, "R10");
        // R1: defaults
        rd(4, "R1"); rd(5, "R1"); rd(6, "R1"); rd(9, "R1"); rd(12, "R1");
        // R2: live readback
        drive(16'hA55A, 4'h3); rd(0, "R2"); rd(1, "R2"); rd(10, "R2");
        drive(16'h0000, 4'h0); rd(0, "R2");
        wr(2, 8'hFF); wr(3, 8'hFF); wr(11, 8'h00);
        // R3: bit0 none, bit1 rise, bit2 fall, bit3 both
        wr(6, 8'b11_10_01_00);
        drive(16'h000F, 4'h0); drive(16'h000F, 4'h0); rd(2, "R3");
        wr(2, 8'hFF);
        drive(16'h0000, 4'h0); drive(16'h0000, 4'h0); rd(2, "R3");
        // R4: partial clear
        drive(16'h000F, 4'h0); drive(16'h000F, 4'h0);
        wr(2, 8'h08); rd(2, "R4"); wr(2, 8'h00); rd(2, "R4");
        wr(2, 8'hFF);
        // R5: set event and clear in the same cycle
        @(negedge clk); evt = 16'h0000; wr_en = 1'b1; addr = 2; wdata = 8'hFF;
        @(negedge clk); wr_en = 1'b0;
        rd(2, "R5");
        wr(2, 8'hFF);
        // R6: enable and watch irq each cycle
        wr(4, 8'h02); drive(16'h0002, 4'h0); repeat (3) @(negedge clk);
        wr(2, 8'h02); repeat (2) @(negedge clk);
        drive(16'h0000, 4'h0); drive(16'h0002, 4'h0); wr(4, 8'h00); repeat (2) @(negedge clk);
        wr(2, 8'hFF); wr(4, 8'hFF); wr(5, 8'hFF);
        // R7: lock bits
        irq_tag = "R7";
        drive(16'h0002, 4'h5); repeat (3) @(negedge clk);
        rd(11, "R7"); wr(11, 8'hFF); rd(11, "R7");
        wr(11, 8'hFE); rd(11, "R7"); wr(11, 8'h00); rd(11, "R7");
        irq_tag = "R6";
        wr(4, 8'h00); wr(5, 8'h00);
        // R8: read-only and unmapped
        wr(0, 8'hFF); wr(10, 8'hFF); rd(0, "R8"); rd(10, "R8"); rd(20, "R8"); rd(31, "R8");
        // R9: configuration readback
        wr(5, 8'h3C); rd(5, "R9"); wr(8, 8'h9A); rd(8, "R9"); wr(12, 8'h1B); rd(12, "R9");
        // random phase
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0;
            if (($urandom % 4) == 0) evt = evt ^ (16'(1) << ($urandom % 16));
            if (($urandom % 16) == 0) lk = lk ^ (4'(1) << ($urandom % 4));
            case ($urandom % 8)
                0: begin wr_en = 1'b1; addr = AW'($urandom % 16); wdata = 8'($urandom); end
                1, 2: begin rd_tag = "R3"; rd_en = 1'b1; addr = AW'($urandom % 16); end
                default: ;
            endcase
        end
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule